// File: doc/BRIEF.md
# Dual-Route Byte FIFO Port

This block sits behind the byte-wide FIFO data address of a storage-bus controller. A host write goes to one of two places. While the command-gathering input is high, the byte is appended to a command store, indexed by a running command length. Otherwise the byte enters a small transfer buffer, which has its own write pointer, read pointer and signed pending-byte counter. Host reads take bytes from the transfer buffer in arrival order. Whenever the last held byte is read, both pointers go back to slot zero.

A status-load strobe fills the transfer buffer with a two-byte reply: the status byte, then 0x00. A consume strobe empties both buffers when a gathered command has been taken. When a write finds no room, the byte is dropped and a one-cycle overrun pulse is raised, with a separate pulse for each buffer.

The transfer buffer is tracked by a three-state machine:
- EMPTY: both pointers are at zero.
- HOLD: data is held and the write pointer is below the last usable slot.
- LIMIT: the write pointer is at depth minus one, and further writes are refused.

Its transitions are:
- EMPTY→HOLD on an accepted write or a status load.
- HOLD→LIMIT when an accepted write reaches the last usable slot.
- HOLD→EMPTY or LIMIT→EMPTY on a draining read or a consume.
- LIMIT→HOLD on a status load.

Top module: `fifo_port`

## Requirements
- R1: After reset, fill level, pending count, command length, read data and both overrun pulses are all zero.
- R2: A write with `collect_cmd` high stores the byte at index `cmd_len` of the command store and increments `cmd_len`. The transfer buffer is not touched.
- R3: A command write when `cmd_len` equals CDEPTH (32) drops the byte, leaves `cmd_len` and the stored bytes unchanged, and pulses `ovr_cmd` high for exactly one cycle.
- R4: A write with `collect_cmd` low, while the write pointer is below XDEPTH-1, stores the byte and raises both fill level and pending count by one.
- R5: A transfer write while the write pointer equals XDEPTH-1 (15) is dropped, leaves the fill level unchanged, and pulses `ovr_xfer` high for one cycle.
- R6: A read while `phase` equals 3'b000 returns 0x00 and pops nothing.
- R7: A read with any other `phase` value, when bytes are held, returns the oldest held byte on `host_rdata` one clock after the read. It then lowers fill level and pending count by one.
- R8: When a read takes the last held byte, both pointers return to zero, so XDEPTH-1 further writes are accepted. A read that leaves bytes held does not rewind the pointers.
- R9: A read with a non-zero `phase` on an empty buffer leaves `host_rdata` and the counts unchanged.
- R10: `status_load` sets the read pointer to 0, the write pointer to 2 and the pending count to 2. The two reads that follow return `status_byte` and then 0x00. Any earlier content is discarded.
- R11: `cmd_consume` clears `cmd_len`, both pointers and the pending count, so the next command byte lands at index 0.
- R12: When several requests coincide, the priority is consume, then status load, then write, then read. A read in the same cycle as a write is ignored.
- R13: The pending count always equals the fill level, and the fill level is the write pointer minus the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write to the FIFO address |
| host_rd | input | 1 | Host read from the FIFO address |
| host_wdata | input | DW | Written byte |
| collect_cmd | input | 1 | Routes writes into the command store |
| phase | input | 3 | Bus phase bits; 3'b000 means data-out |
| status_load | input | 1 | Load the two-byte status reply |
| status_byte | input | DW | Status value for the reply |
| cmd_consume | input | 1 | Command taken; clear both buffers |
| cmd_idx | input | CIW | Command store readout index |
| host_rdata | output | DW | Byte returned by the last read |
| cmd_byte | output | DW | Command store byte at `cmd_idx` |
| cmd_len | output | CIW+1 | Bytes gathered in the command store |
| pending | output | PW+1 | Signed pending-byte count |
| fifo_fill | output | PW+1 | Write pointer minus read pointer |
| ovr_cmd | output | 1 | Command write dropped (one-cycle pulse) |
| ovr_xfer | output | 1 | Transfer write dropped (one-cycle pulse) |

## Verification
Several properties are checked on every cycle by assertions:
- Pending count and fill level agree.
- The read pointer never passes the write pointer, and equal pointers only ever sit at zero.
- Every transfer overrun pulse follows a write made at the limit slot.
- Data-out reads return zero without popping.
- A status load and a consume leave the counts the requirements name.

Other behaviour can only be shown by the bench's scenarios:
- The byte order of reads.
- The exact number of writes accepted after a draining read versus a partial read.
- Command-store contents at chosen indices.
- The outcome of coinciding requests.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CONSUME,
        OP_STATUS,
        OP_CMDWR,
        OP_XWR,
        OP_RD
    } host_op_e;

    typedef enum logic [1:0] {
        XS_EMPTY,
        XS_HOLD,
        XS_LIMIT
    } xbuf_state_e;

endpackage

// File: rtl/fifo_port_arb.sv
module fifo_port_arb
    import fifo_port_pkg::*;
(
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       collect_cmd,
    input  logic       status_load,
    input  logic       cmd_consume,
    input  logic [2:0] phase,
    output host_op_e   op,
    output logic       dout_phase
);

    // Priority: consume, status load, write, read
    always_comb begin
        if (cmd_consume)      op = OP_CONSUME;
        else if (status_load) op = OP_STATUS;
        else if (host_wr)     op = collect_cmd ? OP_CMDWR : OP_XWR;
        else if (host_rd)     op = OP_RD;
        else                  op = OP_NONE;
    end

    assign dout_phase = (phase == 3'b000);

endmodule

// File: rtl/fifo_port_xbuf.sv
module fifo_port_xbuf
    import fifo_port_pkg::*;
#(
    parameter int XDEPTH = 16,
    parameter int DW     = 8,
    localparam int PW    = $clog2(XDEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  host_op_e             op,
    input  logic                 dout_phase,
    input  logic [DW-1:0]        wdata,
    input  logic [DW-1:0]        status_byte,
    output logic [DW-1:0]        rdata,
    output logic [PW-1:0]        wptr,
    output logic [PW-1:0]        rptr,
    output logic signed [PW:0]   pending,
    output logic [PW:0]          fill,
    output logic                 ovr
);

    localparam logic [PW-1:0]        LIM  = PW'(XDEPTH - 1);
    localparam logic [PW-1:0]        ONE  = PW'(1);
    localparam logic [PW-1:0]        TWO  = PW'(2);
    localparam logic signed [PW:0]   PONE = (PW+1)'(1);
    localparam logic signed [PW:0]   PTWO = (PW+1)'(2);

    xbuf_state_e state_q, state_d;
    logic [DW-1:0] mem [XDEPTH];

    logic wr_take, rd_pop, rd_drain;

    assign wr_take  = (op == OP_XWR) && (state_q != XS_LIMIT);
    assign rd_pop   = (op == OP_RD) && !dout_phase && (rptr < wptr);
    assign rd_drain = rd_pop && ((rptr + ONE) == wptr);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_EMPTY: begin
                if (op == OP_STATUS || wr_take) state_d = XS_HOLD;
            end
            XS_HOLD: begin
                if (op == OP_CONSUME || rd_drain)         state_d = XS_EMPTY;
                else if (wr_take && (wptr + ONE) == LIM)  state_d = XS_LIMIT;
            end
            XS_LIMIT: begin
                if (op == OP_CONSUME || rd_drain) state_d = XS_EMPTY;
                else if (op == OP_STATUS)         state_d = XS_HOLD;
            end
            default: state_d = XS_EMPTY;
        endcase
    end

    // Pointer, count and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            pending <= '0;
            rdata   <= '0;
            ovr     <= 1'b0;
        end else begin
            ovr <= 1'b0;
            unique case (op)
                OP_CONSUME: begin
                    wptr    <= '0;
                    rptr    <= '0;
                    pending <= '0;
                end
                OP_STATUS: begin
                    rptr    <= '0;
                    wptr    <= TWO;
                    pending <= PTWO;
                end
                OP_XWR: begin
                    if (state_q == XS_LIMIT) begin
                        ovr <= 1'b1;
                    end else begin
                        wptr    <= wptr + ONE;
                        pending <= pending + PONE;
                    end
                end
                OP_RD: begin
                    if (dout_phase) begin
                        rdata <= '0;
                        if (rptr == wptr) begin
                            wptr <= '0;
                            rptr <= '0;
                        end
                    end else if (rd_pop) begin
                        rdata   <= mem[rptr];
                        pending <= pending - PONE;
                        if (rd_drain) begin
                            wptr <= '0;
                            rptr <= '0;
                        end else begin
                            rptr <= rptr + ONE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Storage
    always_ff @(posedge clk) begin
        if (op == OP_STATUS) begin
            mem[0] <= status_byte;
            mem[1] <= '0;
        end else if (wr_take) begin
            mem[wptr] <= wdata;
        end
    end

    assign fill = {1'b0, wptr} - {1'b0, rptr};

endmodule

// File: rtl/fifo_port_cbuf.sv
module fifo_port_cbuf
    import fifo_port_pkg::*;
#(
    parameter int CDEPTH = 32,
    parameter int DW     = 8,
    localparam int CIW   = $clog2(CDEPTH),
    localparam int CLW   = CIW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  host_op_e        op,
    input  logic [DW-1:0]   wdata,
    input  logic [CIW-1:0]  rd_idx,
    output logic [DW-1:0]   rd_byte,
    output logic [CLW-1:0]  len,
    output logic            ovr
);

    localparam logic [CLW-1:0] FULL = CLW'(CDEPTH);
    localparam logic [CLW-1:0] LONE = CLW'(1);

    logic [DW-1:0] mem [CDEPTH];
    logic          take;

    assign take = (op == OP_CMDWR) && (len != FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
            ovr <= 1'b0;
        end else begin
            ovr <= (op == OP_CMDWR) && (len == FULL);
            if (op == OP_CONSUME) len <= '0;
            else if (take)        len <= len + LONE;
        end
    end

    always_ff @(posedge clk) begin
        if (take) mem[len[CIW-1:0]] <= wdata;
    end

    assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/fifo_port.sv
module fifo_port
    import fifo_port_pkg::*;
#(
    parameter int XDEPTH = 16,
    parameter int CDEPTH = 32,
    parameter int DW     = 8,
    localparam int PW    = $clog2(XDEPTH),
    localparam int CIW   = $clog2(CDEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [DW-1:0]       host_wdata,
    input  logic                collect_cmd,
    input  logic [2:0]          phase,
    input  logic                status_load,
    input  logic [DW-1:0]       status_byte,
    input  logic                cmd_consume,
    input  logic [CIW-1:0]      cmd_idx,
    output logic [DW-1:0]       host_rdata,
    output logic [DW-1:0]       cmd_byte,
    output logic [CIW:0]        cmd_len,
    output logic signed [PW:0]  pending,
    output logic [PW:0]         fifo_fill,
    output logic                ovr_cmd,
    output logic                ovr_xfer
);

    host_op_e        op;
    logic            dout_phase;
    logic [PW-1:0]   xb_wptr;
    logic [PW-1:0]   xb_rptr;

    fifo_port_arb u_arb (
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .collect_cmd (collect_cmd),
        .status_load (status_load),
        .cmd_consume (cmd_consume),
        .phase       (phase),
        .op          (op),
        .dout_phase  (dout_phase)
    );

    fifo_port_xbuf #(.XDEPTH(XDEPTH), .DW(DW)) u_xbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .dout_phase  (dout_phase),
        .wdata       (host_wdata),
        .status_byte (status_byte),
        .rdata       (host_rdata),
        .wptr        (xb_wptr),
        .rptr        (xb_rptr),
        .pending     (pending),
        .fill        (fifo_fill),
        .ovr         (ovr_xfer)
    );

    fifo_port_cbuf #(.CDEPTH(CDEPTH), .DW(DW)) u_cbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wdata   (host_wdata),
        .rd_idx  (cmd_idx),
        .rd_byte (cmd_byte),
        .len     (cmd_len),
        .ovr     (ovr_cmd)
    );

endmodule

// File: rtl/fifo_port_chk.sv
module fifo_port_chk #(
    parameter int XDEPTH = 16,
    parameter int CDEPTH = 32,
    parameter int DW     = 8,
    localparam int PW    = $clog2(XDEPTH),
    localparam int CIW   = $clog2(CDEPTH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_wr,
    input logic                host_rd,
    input logic                collect_cmd,
    input logic [2:0]          phase,
    input logic                status_load,
    input logic                cmd_consume,
    input logic [DW-1:0]       host_rdata,
    input logic [CIW:0]        cmd_len,
    input logic signed [PW:0]  pending,
    input logic [PW:0]         fifo_fill,
    input logic                ovr_cmd,
    input logic                ovr_xfer,
    input logic [PW-1:0]       xb_wptr,
    input logic [PW-1:0]       xb_rptr
);

    localparam logic [PW-1:0] LIM   = PW'(XDEPTH - 1);
    localparam logic [CIW:0]  CFULL = (CIW+1)'(CDEPTH);
    localparam logic [PW:0]   FTWO  = (PW+1)'(2);

    // R13
    pending_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending == $signed(fifo_fill));

    // R8
    ptr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_rptr <= xb_wptr) && ((xb_rptr == xb_wptr) -> (xb_wptr == '0)));

    // R6
    dout_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !status_load && !cmd_consume && phase == 3'b000)
        |=> (host_rdata == '0) && $stable(fifo_fill));

    // R3
    cmd_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && collect_cmd && !status_load && !cmd_consume && cmd_len == CFULL)
        |=> ovr_cmd && (cmd_len == CFULL));

    // R5
    xfer_ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_xfer |-> $past(host_wr && !collect_cmd && !status_load && !cmd_consume
                           && xb_wptr == LIM));

    // R10
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_load && !cmd_consume)
        |=> (fifo_fill == FTWO) && (xb_rptr == '0));

    // R11
    consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_consume |=> (cmd_len == '0) && (fifo_fill == '0) && (pending == '0));

endmodule

bind fifo_port fifo_port_chk #(.XDEPTH(XDEPTH), .CDEPTH(CDEPTH), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .collect_cmd (collect_cmd),
    .phase       (phase),
    .status_load (status_load),
    .cmd_consume (cmd_consume),
    .host_rdata  (host_rdata),
    .cmd_len     (cmd_len),
    .pending     (pending),
    .fifo_fill   (fifo_fill),
    .ovr_cmd     (ovr_cmd),
    .ovr_xfer    (ovr_xfer),
    .xb_wptr     (xb_wptr),
    .xb_rptr     (xb_rptr)
);

// File: tb/fifo_port_tb_top.sv
`timescale 1ns/1ps
module fifo_port_tb_top;

    localparam int XDEPTH = 16;
    localparam int CDEPTH = 32;
    localparam int DW     = 8;
    localparam int PW     = $clog2(XDEPTH);
    localparam int CIW    = $clog2(CDEPTH);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_wr = 1'b0;
    logic               host_rd = 1'b0;
    logic [DW-1:0]      host_wdata = '0;
    logic               collect_cmd = 1'b0;
    logic [2:0]         phase = 3'b001;
    logic               status_load = 1'b0;
    logic [DW-1:0]      status_byte = '0;
    logic               cmd_consume = 1'b0;
    logic [CIW-1:0]     cmd_idx = '0;
    logic [DW-1:0]      host_rdata;
    logic [DW-1:0]      cmd_byte;
    logic [CIW:0]       cmd_len;
    logic signed [PW:0] pending;
    logic [PW:0]        fifo_fill;
    logic               ovr_cmd;
    logic               ovr_xfer;

    int total = 0;
    int bad   = 0;

    int    exp_q [$];
    string tag_q [$];
    int    mon_v;
    string mon_t;

    always #4 clk = ~clk;

    fifo_port #(.XDEPTH(XDEPTH), .CDEPTH(CDEPTH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .collect_cmd(collect_cmd), .phase(phase),
        .status_load(status_load), .status_byte(status_byte),
        .cmd_consume(cmd_consume), .cmd_idx(cmd_idx), .host_rdata(host_rdata),
        .cmd_byte(cmd_byte), .cmd_len(cmd_len), .pending(pending),
        .fifo_fill(fifo_fill), .ovr_cmd(ovr_cmd), .ovr_xfer(ovr_xfer)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_lvl(string tag, int lvl);
        chk({tag, " fill"}, int'(fifo_fill), lvl);
        chk({tag, " pending"}, int'(pending), lvl);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        host_wdata = d;
        host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Driver: pushes the expected byte, monitor compares it
    task automatic rd_exp(int e, string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_raw();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load_status(logic [7:0] b);
        @(negedge clk);
        status_byte = b;
        status_load = 1'b1;
        @(negedge clk);
        status_load = 1'b0;
    endtask

    task automatic consume();
        @(negedge clk);
        cmd_consume = 1'b1;
        @(negedge clk);
        cmd_consume = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Monitor: compares read data after each expected read
    always @(posedge clk) begin
        if (host_rd && exp_q.size() > 0) begin
            #2;
            mon_v = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(mon_t, int'(host_rdata), mon_v);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=finish");
        summary();
        $finish;
    end

    initial begin
        int acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_lvl("R1", 0);
        chk("R1 cmd_len", int'(cmd_len), 0);
        chk("R1 rdata", int'(host_rdata), 0);
        chk("R1 ovr", int'(ovr_cmd) + int'(ovr_xfer), 0);

        // R4 transfer writes
        wr(8'hA1); chk_lvl("R4 one", 1);
        wr(8'hA2); wr(8'hA3); chk_lvl("R4 three", 3);
        // R7 ordered reads
        rd_exp(8'hA1, "R7 first");
        rd_exp(8'hA2, "R7 second");
        chk_lvl("R7 after two", 1);
        rd_exp(8'hA3, "R7 third");
        chk_lvl("R8 drained", 0);

        // R8 rewind lets XDEPTH-1 writes in; R5 the next is dropped
        for (int i = 0; i < XDEPTH; i++) begin
            wr(8'(8'h10 + i));
            if (i < XDEPTH - 1) chk("R8 accepted after rewind", int'(ovr_xfer), 0);
        end
        chk("R5 ovr pulse", int'(ovr_xfer), 1);
        chk_lvl("R5 level kept", XDEPTH - 1);
        @(negedge clk);
        chk("R5 ovr one cycle", int'(ovr_xfer), 0);
        for (int i = 0; i < XDEPTH - 1; i++) rd_exp(8'h10 + i, "R7 full drain order");
        chk_lvl("R8 full drain", 0);

        // R8 partial read does not rewind
        wr(8'h30); wr(8'h31); wr(8'h32);
        rd_exp(8'h30, "R7 partial");
        chk_lvl("R8 partial level", 2);
        acc = 0;
        for (int i = 0; i < 13; i++) begin
            wr(8'(8'h40 + i));
            if (!ovr_xfer) acc++;
        end
        chk("R8 no rewind accepted", acc, XDEPTH - 1 - 3);
        rd_exp(8'h31, "R7 after partial");
        rd_exp(8'h32, "R7 after partial");
        for (int i = 0; i < 12; i++) rd_exp(8'h40 + i, "R7 after partial");
        chk_lvl("R8 partial drained", 0);

        // R6 data-out read returns zero, no pop
        phase = 3'b000;
        wr(8'h55); wr(8'h66);
        rd_raw();
        chk("R6 zero data", int'(host_rdata), 0);
        chk_lvl("R6 not popped", 2);
        phase = 3'b001;
        rd_exp(8'h55, "R6 first byte kept");
        rd_exp(8'h66, "R7 second byte");

        // R9 empty read
        rd_raw();
        chk("R9 rdata held", int'(host_rdata), 8'h66);
        chk_lvl("R9 counts", 0);

        // R10 status reply, also over held data
        load_status(8'hC7);
        chk_lvl("R10 level", 2);
        rd_exp(8'hC7, "R10 status byte");
        rd_exp(8'h00, "R10 zero byte");
        chk_lvl("R10 drained", 0);
        wr(8'hAA); wr(8'hAB); wr(8'hAC);
        load_status(8'h3C);
        chk_lvl("R10 overwrite", 2);
        rd_exp(8'h3C, "R10 status over data");
        rd_exp(8'h00, "R10 zero over data");

        // R2 / R3 command gathering
        collect_cmd = 1'b1;
        wr(8'h20); wr(8'h21); wr(8'h22);
        chk("R2 len", int'(cmd_len), 3);
        chk_lvl("R2 xfer untouched", 0);
        for (int i = 3; i < CDEPTH; i++) wr(8'(8'h20 + i));
        chk("R2 len full", int'(cmd_len), CDEPTH);
        cmd_idx = 5'd1; #1;
        chk("R2 byte idx1", int'(cmd_byte), 8'h21);
        cmd_idx = 5'd31; #1;
        chk("R2 byte idx31", int'(cmd_byte), 8'h3F);
        wr(8'h99);
        chk("R3 ovr pulse", int'(ovr_cmd), 1);
        chk("R3 len kept", int'(cmd_len), CDEPTH);
        chk("R3 byte kept", int'(cmd_byte), 8'h3F);
        @(negedge clk);
        chk("R3 ovr one cycle", int'(ovr_cmd), 0);

        // R11 consume
        collect_cmd = 1'b0;
        wr(8'h77); wr(8'h78);
        consume();
        chk("R11 len", int'(cmd_len), 0);
        chk_lvl("R11 xfer", 0);
        collect_cmd = 1'b1;
        wr(8'h5A);
        cmd_idx = 5'd0; #1;
        chk("R11 restart idx0", int'(cmd_byte), 8'h5A);
        chk("R11 restart len", int'(cmd_len), 1);
        collect_cmd = 1'b0;

        // R12 priorities
        @(negedge clk);
        cmd_consume = 1'b1; status_load = 1'b1; status_byte = 8'h81;
        @(negedge clk);
        cmd_consume = 1'b0; status_load = 1'b0;
        chk_lvl("R12 consume over status", 0);
        chk("R12 consume len", int'(cmd_len), 0);
        @(negedge clk);
        status_load = 1'b1; host_wr = 1'b1; host_wdata = 8'h11;
        @(negedge clk);
        status_load = 1'b0; host_wr = 1'b0;
        chk_lvl("R12 status over write", 2);
        rd_exp(8'h81, "R12 status byte");
        rd_exp(8'h00, "R12 zero byte");
        wr(8'h21);
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_wdata = 8'h22;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk_lvl("R12 write over read", 2);
        rd_exp(8'h21, "R12 order");
        rd_exp(8'h22, "R12 order");
        chk_lvl("R13 final", 0);

        repeat (2) @(negedge clk);
        chk("R7 monitor queue empty", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule